// File: doc/BRIEF.md
# Cascadable Beam Summation Stage

This block is one link in a chain of array-processing boards. Each board has four complex channel streams that are already phase and gain corrected. The block adds them into a single local beam sample. It then adds the partial beam that the previous board in the chain has accumulated and hands the total on, so that the next board can extend it. The last board in the chain sends its total to a host-facing port and not downstream.

Local and upstream samples reach the block at different times. Each local beam sample therefore waits in a small alignment queue until its upstream partner turns up. Every stream uses valid/ready. A word moves on a clock edge where both valid and ready are high. A source keeps valid and data steady until that edge.

The local lanes are joined, not queued. A lane's ready depends only on the enabled lanes' valids and never on queue space. If the upstream stream falls behind by more than the queue can hold, a sticky error flag records the loss and the queue is emptied. The two outputs share one register stage, so back-pressure on the selected output stalls the queue. The configuration pins are plain levels and stay static while traffic flows.

Top module: `beam_sum_stage`

## Requirements
- R1: A local sample is taken on the edge where every lane enabled in `cfg_lane_en` shows valid. At that edge all enabled lanes see ready together. A lane whose enable bit is 0 always shows ready high, and its data and valid have no effect. When no lane is enabled, no local sample is formed.
- R2: Each output component equals the signed sum of the enabled lanes' 16-bit components plus the sum-in term. The result is saturated to the 20-bit signed range [-524288, 524287]. I and Q are computed independently.
- R3: With `cfg_sumin_en` = 0 the sum-in term is zero and `sin_ready` stays low. If the output register is empty, the result is valid on the second rising edge after the lane handshake.
- R4: With `cfg_sumin_en` = 1, local samples are paired with sum-in samples in arrival order. `sin_ready` is high only while a local sample is waiting and the output register can take a result.
- R5: With `cfg_last` = 1 results appear on the host port and `sout_valid` stays low. With `cfg_last` = 0 results appear on the sum-out port and `host_valid` stays low.
- R6: A valid result stays valid, with unchanged data, until the selected port's ready is high at a clock edge.
- R7: The alignment queue holds 16 local samples. Suppose a lane handshake occurs while 16 samples are waiting and none leaves in that cycle. Then `align_err` goes high and stays high until reset, and the waiting samples and the new sample are all discarded.
- R8: After reset `sout_valid`, `host_valid`, `sin_ready` and `align_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lane_en | input | 4 | Per-lane enable |
| cfg_sumin_en | input | 1 | Expect an upstream partial sum |
| cfg_last | input | 1 | Last stage: route totals to the host port |
| lane_valid | input | 4 | Per-lane valid |
| lane_ready | output | 4 | Per-lane ready |
| lane_i | input | 64 | Lane in-phase components, lane k at bits 16k+15:16k |
| lane_q | input | 64 | Lane quadrature components, same packing |
| sin_valid | input | 1 | Upstream partial sum valid |
| sin_ready | output | 1 | Upstream partial sum ready |
| sin_i | input | 20 | Upstream partial sum, in-phase |
| sin_q | input | 20 | Upstream partial sum, quadrature |
| sout_valid | output | 1 | Downstream total valid |
| sout_ready | input | 1 | Downstream total ready |
| sout_i | output | 20 | Downstream total, in-phase |
| sout_q | output | 20 | Downstream total, quadrature |
| host_valid | output | 1 | Host total valid |
| host_ready | input | 1 | Host total ready |
| host_i | output | 20 | Host total, in-phase |
| host_q | output | 20 | Host total, quadrature |
| align_err | output | 1 | Sticky alignment overflow flag |

## Verification
The bench builds the block with its default parameters: four lanes of 16 bits, a 20-bit total and a 16-entry queue. At these widths the four lanes alone can never saturate the total, so both saturation limits are reached by driving extreme upstream partial sums together with full-scale lanes. A 16-deep queue makes the overflow path reachable with seventeen local samples and no upstream traffic. Random runs cover three chain positions (first, middle, last) with random enables, gaps and output stalls.

// File: rtl/beam_pkg.sv
package beam_pkg;
  typedef enum logic {
    DEST_DOWNSTREAM = 1'b0,
    DEST_HOST       = 1'b1
  } dest_e;
endpackage

// File: rtl/beam_lane_join.sv
module beam_lane_join #(
  parameter int NCH  = 4,
  parameter int IN_W = 16,
  parameter int LW   = 18
) (
  input  logic [NCH-1:0]      en,
  input  logic [NCH-1:0]      valid,
  input  logic [NCH*IN_W-1:0] din_i,
  input  logic [NCH*IN_W-1:0] din_q,
  output logic [NCH-1:0]      ready,
  output logic                fire,
  output logic [LW-1:0]       sum_i,
  output logic [LW-1:0]       sum_q
);
  logic [LW-1:0] ext_i [NCH];
  logic [LW-1:0] ext_q [NCH];

  assign fire = (|en) && (&(valid | ~en));

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    assign ext_i[k] = {{(LW-IN_W){din_i[k*IN_W+IN_W-1]}}, din_i[k*IN_W +: IN_W]};
    assign ext_q[k] = {{(LW-IN_W){din_q[k*IN_W+IN_W-1]}}, din_q[k*IN_W +: IN_W]};
    assign ready[k] = ~en[k] | fire;
  end

  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < NCH; k++) begin
      if (en[k]) begin
        sum_i = sum_i + ext_i[k];
        sum_q = sum_q + ext_q[k];
      end
    end
  end
endmodule

// File: rtl/beam_align_fifo.sv
module beam_align_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign overflow = push && full && !pop;
  assign dout     = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || overflow) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !overflow) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/beam_out_route.sv
module beam_out_route #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] din_q,
  input  logic         to_host,
  input  logic         sout_ready,
  input  logic         host_ready,
  output logic         can_load,
  output logic         sout_valid,
  output logic [W-1:0] sout_i,
  output logic [W-1:0] sout_q,
  output logic         host_valid,
  output logic [W-1:0] host_i,
  output logic [W-1:0] host_q
);
  logic         vld;
  logic [W-1:0] r_i, r_q;
  logic         take;

  assign take     = to_host ? host_ready : sout_ready;
  assign can_load = !vld || take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      r_i <= '0;
      r_q <= '0;
    end else if (load) begin
      vld <= 1'b1;
      r_i <= din_i;
      r_q <= din_q;
    end else if (take) begin
      vld <= 1'b0;
    end
  end

  assign sout_valid = vld && !to_host;
  assign host_valid = vld && to_host;
  assign sout_i = r_i;
  assign sout_q = r_q;
  assign host_i = r_i;
  assign host_q = r_q;
endmodule

// File: rtl/beam_sum_stage.sv
module beam_sum_stage
  import beam_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int IN_W  = 16,
  parameter int OUT_W = 20,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      cfg_lane_en,
  input  logic                cfg_sumin_en,
  input  logic                cfg_last,
  input  logic [NCH-1:0]      lane_valid,
  output logic [NCH-1:0]      lane_ready,
  input  logic [NCH*IN_W-1:0] lane_i,
  input  logic [NCH*IN_W-1:0] lane_q,
  input  logic                sin_valid,
  output logic                sin_ready,
  input  logic [OUT_W-1:0]    sin_i,
  input  logic [OUT_W-1:0]    sin_q,
  output logic                sout_valid,
  input  logic                sout_ready,
  output logic [OUT_W-1:0]    sout_i,
  output logic [OUT_W-1:0]    sout_q,
  output logic                host_valid,
  input  logic                host_ready,
  output logic [OUT_W-1:0]    host_i,
  output logic [OUT_W-1:0]    host_q,
  output logic                align_err
);
  localparam int LW = IN_W + $clog2(NCH);
  localparam int XW = OUT_W + 1;

  logic          fire, empty, overflow, pop, can_load;
  logic [LW-1:0] loc_i, loc_q, head_i, head_q;
  logic [XW-1:0] tot_i, tot_q;
  logic [OUT_W-1:0] res_i, res_q;
  dest_e         dest;

  beam_lane_join #(.NCH(NCH), .IN_W(IN_W), .LW(LW)) u_join (
    .en(cfg_lane_en), .valid(lane_valid), .din_i(lane_i), .din_q(lane_q),
    .ready(lane_ready), .fire(fire), .sum_i(loc_i), .sum_q(loc_q)
  );

  beam_align_fifo #(.W(2*LW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fire), .din({loc_i, loc_q}),
    .pop(pop), .dout({head_i, head_q}), .empty(empty), .overflow(overflow)
  );

  assign sin_ready = cfg_sumin_en && !empty && can_load;
  assign pop       = !empty && can_load && (!cfg_sumin_en || sin_valid);

  function automatic logic [XW-1:0] widen_loc(input logic [LW-1:0] v);
    return {{(XW-LW){v[LW-1]}}, v};
  endfunction

  function automatic logic [XW-1:0] widen_sin(input logic [OUT_W-1:0] v);
    return cfg_sumin_en ? {v[OUT_W-1], v} : '0;
  endfunction

  function automatic logic [OUT_W-1:0] clip(input logic [XW-1:0] v);
    if (v[XW-1] != v[XW-2])
      return v[XW-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    return v[OUT_W-1:0];
  endfunction

  assign tot_i = widen_loc(head_i) + widen_sin(sin_i);
  assign tot_q = widen_loc(head_q) + widen_sin(sin_q);
  assign res_i = clip(tot_i);
  assign res_q = clip(tot_q);

  assign dest = dest_e'(cfg_last);

  beam_out_route #(.W(OUT_W)) u_route (
    .clk(clk), .rst_n(rst_n), .load(pop), .din_i(res_i), .din_q(res_q),
    .to_host(dest == DEST_HOST), .sout_ready(sout_ready), .host_ready(host_ready),
    .can_load(can_load), .sout_valid(sout_valid), .sout_i(sout_i), .sout_q(sout_q),
    .host_valid(host_valid), .host_i(host_i), .host_q(host_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        align_err <= 1'b0;
    else if (overflow) align_err <= 1'b1;
  end
endmodule

// File: rtl/beam_sum_checks.sv
module beam_sum_checks #(
  parameter int NCH   = 4,
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   cfg_lane_en,
  input logic             cfg_sumin_en,
  input logic [NCH-1:0]   lane_valid,
  input logic [NCH-1:0]   lane_ready,
  input logic             sin_valid,
  input logic             sin_ready,
  input logic             sout_valid,
  input logic             sout_ready,
  input logic [OUT_W-1:0] sout_i,
  input logic [OUT_W-1:0] sout_q,
  input logic             host_valid,
  input logic             host_ready,
  input logic [OUT_W-1:0] host_i,
  input logic [OUT_W-1:0] host_q,
  input logic             align_err
);
  logic out_any;
  assign out_any = sout_valid || host_valid;

  assert_hold_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !sout_ready) |=> (sout_valid && $stable(sout_i) && $stable(sout_q)));

  assert_hold_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready) |=> (host_valid && $stable(host_i) && $stable(host_q)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_err) |-> $past(|(lane_valid & lane_ready & cfg_lane_en)));

  assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_any) && cfg_sumin_en) |-> $past(sin_valid && sin_ready));
endmodule

bind beam_sum_stage beam_sum_checks #(.NCH(NCH), .OUT_W(OUT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_lane_en(cfg_lane_en), .cfg_sumin_en(cfg_sumin_en),
  .lane_valid(lane_valid), .lane_ready(lane_ready),
  .sin_valid(sin_valid), .sin_ready(sin_ready),
  .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_i(sout_i), .sout_q(sout_q),
  .host_valid(host_valid), .host_ready(host_ready), .host_i(host_i), .host_q(host_q),
  .align_err(align_err)
);

// File: tb/sim_beam_sum_stage.sv
module sim_beam_sum_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_lane_en = 4'hF;
  logic        cfg_sumin_en = 1'b0;
  logic        cfg_last = 1'b0;
  logic [3:0]  lane_valid = '0;
  logic [3:0]  lane_ready;
  logic [63:0] lane_i = '0, lane_q = '0;
  logic        sin_valid = 1'b0;
  logic        sin_ready;
  logic [19:0] sin_i = '0, sin_q = '0;
  logic        sout_valid, host_valid;
  logic        sout_ready = 1'b0, host_ready = 1'b0;
  logic [19:0] sout_i, sout_q, host_i, host_q;
  logic        align_err;

  always #5 clk = ~clk;

  beam_sum_stage u0 (.*);

  int checks = 0, errors = 0, n_loc = 0, n_out = 0;
  int exp_li[$], exp_lq[$], exp_si[$], exp_sq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lsum(input logic [3:0] en, input logic [63:0] d);
    int s = 0;
    for (int k = 0; k < 4; k++) if (en[k]) s += int'($signed(d[k*16 +: 16]));
    return s;
  endfunction

  function automatic int sat20(input longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return int'(v);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    lane_valid = '0; sin_valid = 1'b0; sout_ready = 1'b0; host_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_li.delete(); exp_lq.delete(); exp_si.delete(); exp_sq.delete();
    n_loc = 0; n_out = 0;
  endtask

  task automatic put_local(input logic [63:0] di, input logic [63:0] dq, input logic [3:0] extra);
    bit hs = 0;
    @(negedge clk);
    lane_i = di; lane_q = dq; lane_valid = cfg_lane_en | extra;
    while (!hs) begin
      #1;
      hs = |(lane_ready & cfg_lane_en);
      if (!hs) @(negedge clk);
    end
    exp_li.push_back(lsum(cfg_lane_en, di));
    exp_lq.push_back(lsum(cfg_lane_en, dq));
    n_loc++;
    @(posedge clk); #1;
    lane_valid = '0;
  endtask

  task automatic put_sin(input int vi, input int vq);
    bit hs = 0;
    @(negedge clk);
    sin_i = 20'(vi); sin_q = 20'(vq); sin_valid = 1'b1;
    while (!hs) begin
      #1;
      hs = sin_ready;
      if (!hs) @(negedge clk);
    end
    exp_si.push_back(vi); exp_sq.push_back(vq);
    @(posedge clk); #1;
    sin_valid = 1'b0;
  endtask

  task automatic get_one(input string tag, input int stall_pct);
    bit got = 0, stalled = 0, rdy, v;
    logic [19:0] hi, hq, di, dq;
    longint ei, eq;
    while (!got) begin
      @(negedge clk);
      di = cfg_last ? host_i : sout_i;
      dq = cfg_last ? host_q : sout_q;
      if (stalled) chk(di == hi && dq == hq, "R6 held data", longint'(di), longint'(hi));
      rdy = ($urandom_range(99) >= stall_pct);
      sout_ready = rdy; host_ready = rdy;
      #1;
      v = cfg_last ? host_valid : sout_valid;
      stalled = v && !rdy;
      hi = di; hq = dq;
      got = v && rdy;
    end
    chk((cfg_last ? sout_valid : host_valid) == 1'b0, "R5 idle port low", 1, 0);
    if (exp_li.size() == 0) begin
      chk(0, {tag, " unexpected output"}, 1, 0);
    end else begin
      ei = exp_li.pop_front(); eq = exp_lq.pop_front();
      if (cfg_sumin_en) begin
        if (exp_si.size() == 0) chk(0, {tag, " missing sum-in"}, 0, 1);
        else begin ei += exp_si.pop_front(); eq += exp_sq.pop_front(); end
      end
      chk(int'($signed(di)) == sat20(ei), {tag, " I"}, int'($signed(di)), sat20(ei));
      chk(int'($signed(dq)) == sat20(eq), {tag, " Q"}, int'($signed(dq)), sat20(eq));
    end
    n_out++;
    @(posedge clk); #1;
    sout_ready = 1'b0; host_ready = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic int rnd_sin();
    int r = int'($urandom_range(3));
    if (r == 0) return 524287 - int'($urandom_range(50000));
    if (r == 1) return -524288 + int'($urandom_range(50000));
    return int'($urandom_range(400000)) - 200000;
  endfunction

  task automatic random_phase(input bit last, input bit sumin, input int n);
    cfg_last = last; cfg_sumin_en = sumin;
    n_loc = 0; n_out = 0;
    fork
      begin
        for (int s = 0; s < n; s++) begin
          cfg_lane_en = cfg_lane_en;
          while (n_loc - n_out >= 10) @(negedge clk);
          repeat ($urandom_range(2)) @(negedge clk);
          put_local(rnd64(), rnd64(), 4'($urandom()));
        end
      end
      begin
        if (sumin)
          for (int s = 0; s < n; s++) begin
            repeat ($urandom_range(3)) @(negedge clk);
            put_sin(rnd_sin(), rnd_sin());
          end
      end
      begin
        for (int s = 0; s < n; s++) get_one("R2 R4 random", 30);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    do_reset();
    #1;
    chk(!sout_valid && !host_valid, "R8 outputs idle", sout_valid | host_valid, 0);
    chk(!sin_ready, "R8 sin_ready", sin_ready, 0);
    chk(!align_err, "R8 align_err", align_err, 0);

    // R1 partial valid and disabled lane; R3 latency and sum-in ignored
    cfg_lane_en = 4'b0101; cfg_sumin_en = 1'b0; cfg_last = 1'b1;
    @(negedge clk);
    lane_valid = 4'b0001; lane_i = 64'h0000_0000_0000_0100; lane_q = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(lane_ready == 4'b1010, "R1 partial join ready", lane_ready, 4'b1010);
    chk(!host_valid, "R1 no sample yet", host_valid, 0);
    sin_valid = 1'b1; sin_i = 20'd1000;
    put_local(64'h0000_00C8_7FFF_0064, 64'hFFFF_0005_1234_FFFE, 4'b0010);
    chk(!host_valid, "R3 not valid after first edge", host_valid, 0);
    chk(!sin_ready, "R3 sin_ready low", sin_ready, 0);
    @(posedge clk); #1;
    chk(host_valid, "R3 valid after second edge", host_valid, 1);
    sin_valid = 1'b0;
    get_one("R1 R3 disabled lane excluded", 0);

    // R2 saturation at both limits
    cfg_lane_en = 4'hF; cfg_sumin_en = 1'b1; cfg_last = 1'b0;
    put_local({4{16'h7FFF}}, {4{16'h8000}}, 4'b0);
    put_sin(524287, -524288);
    get_one("R2 saturate", 0);
    put_local({4{16'h8000}}, {4{16'h7FFF}}, 4'b0);
    put_sin(-524288, 524287);
    get_one("R2 saturate", 0);

    // Random traffic: last stage, first stage, middle stage
    cfg_lane_en = 4'b1011;
    random_phase(1'b1, 1'b1, 200);
    cfg_lane_en = 4'b0110;
    random_phase(1'b0, 1'b0, 200);
    cfg_lane_en = 4'hF;
    random_phase(1'b0, 1'b1, 200);

    // R7 overflow and flush
    do_reset();
    cfg_lane_en = 4'hF; cfg_sumin_en = 1'b1; cfg_last = 1'b0;
    for (int s = 0; s < 16; s++) put_local(rnd64(), rnd64(), 4'b0);
    chk(!align_err, "R7 sixteen fit", align_err, 0);
    put_local(rnd64(), rnd64(), 4'b0);
    chk(align_err, "R7 overflow flag", align_err, 1);
    exp_li.delete(); exp_lq.delete();
    chk(!sin_ready, "R7 queue flushed", sin_ready, 0);
    put_local(64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, 4'b0);
    put_sin(7, -9);
    get_one("R7 after flush", 0);
    chk(align_err, "R7 sticky", align_err, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule